// File: doc/BRIEF.md
# Display Privileged Register Front End with Event Trace

This block sits at the write side of a display unit's privileged control space. A host issues single-cycle register writes, each made of a 16-bit offset and a 64-bit data word qualified by a one-cycle write strobe. Nothing can be read back. Two offsets are recognised.

The background colour register drives three 8-bit colour channels continuously. These channels come up mid-grey after reset. The display mode register is only recorded and drives no output. Any other offset is silently dropped.

Each recognised write also produces one typed record on a trace port. Downstream logging or debug capture can consume these records. Each record carries a subsystem code, an event code, four argument words and a flags word. The record appears on the cycle that follows the write.

Top module: `disp_priv_regs`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next clock edge sets all three colour outputs to 0x40 and clears `trc_valid` to 0.
- R2: A write with offset 0x00E0 loads red from data bits [23:16], green from bits [15:8] and blue from bits [7:0]. The new colour is visible on the cycle after the strobe, which is within two cycles.
- R3: In any cycle without a background colour write, the colour outputs keep their previous value for as long as no such write occurs.
- R4: A write with offset 0x0000 is the display mode register. It emits an event with event code 0x11 and leaves the colour outputs unchanged.
- R5: Each background colour write emits exactly one event with event code 0x10. Every event carries subsystem code 0x02.
- R6: `trc_valid` is high for exactly the one cycle after each accepted write, and low in every cycle that does not follow an accepted write. Back-to-back writes give back-to-back pulses.
- R7: During an event, `trc_arg0` is the offset zero-extended to 64 bits and `trc_arg1` is the full write data. `trc_arg2`, `trc_arg3` and `trc_flags` are zero. When `trc_valid` is low, all trace fields read zero.
- R8: A write to any offset other than 0x00E0 and 0x0000 emits no event and leaves the colour outputs unchanged.
- R9: Data bits [63:24] of a background colour write have no effect on the colour outputs.
- R10: A later background colour write fully replaces the colour set by an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_off | input | 16 | Register offset |
| wr_data | input | 64 | Write data |
| bg_red | output | 8 | Background red channel |
| bg_green | output | 8 | Background green channel |
| bg_blue | output | 8 | Background blue channel |
| trc_valid | output | 1 | Trace record valid pulse |
| trc_subsys | output | 8 | Subsystem code |
| trc_event | output | 8 | Event code |
| trc_arg0 | output | 64 | Zero-extended offset |
| trc_arg1 | output | 64 | Write data |
| trc_arg2 | output | 64 | Reserved, zero |
| trc_arg3 | output | 64 | Reserved, zero |
| trc_flags | output | 32 | Reserved, zero |

## Verification
A background colour write changes the colour channels and raises the trace record on the same clock edge. Both results must therefore agree in the same sampled cycle. The bench provokes this with directed and random writes to 0x00E0, including back-to-back writes and writes that mix colour, mode and unknown offsets. After every clock it compares the colour channels and the complete trace record against a reference model that steps the same stimulus. A mismatch in either half of that shared cycle is reported.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int OFF_W  = 16;
    localparam int DATA_W = 64;
    localparam int CH_W   = 8;
    localparam int ARG_W  = 64;
    localparam int FLAG_W = 32;
    localparam int CODE_W = 8;
    localparam int PAD_W  = ARG_W - OFF_W;

    localparam logic [CODE_W-1:0] SUBSYS_DISPLAY = 8'h02;
    localparam logic [CODE_W-1:0] EVT_BGCOL      = 8'h10;
    localparam logic [CODE_W-1:0] EVT_MODE       = 8'h11;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_BGCOL = 2'd1,
        KIND_MODE  = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] subsys;
        logic [CODE_W-1:0] evt;
        logic [ARG_W-1:0]  a0;
        logic [ARG_W-1:0]  a1;
        logic [ARG_W-1:0]  a2;
        logic [ARG_W-1:0]  a3;
        logic [FLAG_W-1:0] flags;
    } trace_rec_t;

    function automatic rgb_t unpack_rgb(input logic [DATA_W-1:0] d);
        rgb_t c;
        c.r = d[3*CH_W-1:2*CH_W];
        c.g = d[2*CH_W-1:CH_W];
        c.b = d[CH_W-1:0];
        return c;
    endfunction

    function automatic rgb_t grey(input logic [CH_W-1:0] lvl);
        rgb_t c;
        c.r = lvl;
        c.g = lvl;
        c.b = lvl;
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] kind_code(input reg_kind_e k);
        case (k)
            KIND_BGCOL: return EVT_BGCOL;
            KIND_MODE:  return EVT_MODE;
            default:    return '0;
        endcase
    endfunction

    function automatic trace_rec_t idle_rec();
        trace_rec_t t;
        t = '0;
        return t;
    endfunction

endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
    import dpr_pkg::*;
#(
    parameter logic [OFF_W-1:0] BG_OFF   = 16'h00E0,
    parameter logic [OFF_W-1:0] MODE_OFF = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    output reg_kind_e        kind
);

    logic hit_bg;
    logic hit_mode;

    always_comb begin
        hit_bg   = wr_en && (wr_off == BG_OFF);
        hit_mode = wr_en && (wr_off == MODE_OFF);
        if (hit_bg)
            kind = KIND_BGCOL;
        else if (hit_mode)
            kind = KIND_MODE;
        else
            kind = KIND_NONE;
    end

    AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_bg, hit_mode}));  // R8

    AST_IDLE_NO_KIND: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> kind == KIND_NONE);  // R8

endmodule

// File: rtl/dpr_colour_latch.sv
module dpr_colour_latch
    import dpr_pkg::*;
#(
    parameter logic [CH_W-1:0] RESET_LEVEL = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output rgb_t              colour
);

    rgb_t colour_q;

    always_ff @(posedge clk) begin
        if (rst)
            colour_q <= grey(RESET_LEVEL);
        else if (load)
            colour_q <= unpack_rgb(data);
    end

    assign colour = colour_q;

    AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(colour));  // R3

    AST_COLOUR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (colour.r == $past(data[23:16])) && (colour.g == $past(data[15:8]))
                 && (colour.b == $past(data[7:0])));  // R2

endmodule

// File: rtl/dpr_trace_fmt.sv
module dpr_trace_fmt
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_kind_e         kind,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output trace_rec_t        rec
);

    trace_rec_t rec_q;
    trace_rec_t rec_d;

    always_comb begin
        rec_d = idle_rec();
        if (kind != KIND_NONE) begin
            rec_d.valid  = 1'b1;
            rec_d.subsys = SUBSYS_DISPLAY;
            rec_d.evt    = kind_code(kind);
            rec_d.a0     = {{PAD_W{1'b0}}, wr_off};
            rec_d.a1     = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rec_q <= idle_rec();
        else
            rec_q <= rec_d;
    end

    assign rec = rec_q;

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rec.valid |-> $past(kind) != KIND_NONE);  // R6

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rec.valid |-> (rec.a2 == '0) && (rec.a3 == '0) && (rec.flags == '0));  // R7

    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rec.valid |-> (rec.a0 == '0) && (rec.a1 == '0) && (rec.evt == '0));  // R7

endmodule

// File: rtl/disp_priv_regs.sv
module disp_priv_regs
    import dpr_pkg::*;
#(
    parameter logic [15:0] BG_OFF      = 16'h00E0,
    parameter logic [15:0] MODE_OFF    = 16'h0000,
    parameter logic [7:0]  RESET_LEVEL = 8'h40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_off,
    input  logic [63:0] wr_data,
    output logic [7:0]  bg_red,
    output logic [7:0]  bg_green,
    output logic [7:0]  bg_blue,
    output logic        trc_valid,
    output logic [7:0]  trc_subsys,
    output logic [7:0]  trc_event,
    output logic [63:0] trc_arg0,
    output logic [63:0] trc_arg1,
    output logic [63:0] trc_arg2,
    output logic [63:0] trc_arg3,
    output logic [31:0] trc_flags
);

    reg_kind_e  kind;
    rgb_t       colour;
    trace_rec_t rec;

    dpr_decode #(
        .BG_OFF   (BG_OFF),
        .MODE_OFF (MODE_OFF)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_off (wr_off),
        .kind   (kind)
    );

    dpr_colour_latch #(
        .RESET_LEVEL (RESET_LEVEL)
    ) u_colour (
        .clk    (clk),
        .rst    (rst),
        .load   (kind == KIND_BGCOL),
        .data   (wr_data),
        .colour (colour)
    );

    dpr_trace_fmt u_trace (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .rec     (rec)
    );

    assign bg_red     = colour.r;
    assign bg_green   = colour.g;
    assign bg_blue    = colour.b;
    assign trc_valid  = rec.valid;
    assign trc_subsys = rec.subsys;
    assign trc_event  = rec.evt;
    assign trc_arg0   = rec.a0;
    assign trc_arg1   = rec.a1;
    assign trc_arg2   = rec.a2;
    assign trc_arg3   = rec.a3;
    assign trc_flags  = rec.flags;

    AST_MODE_KEEPS_COLOUR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == MODE_OFF) |=> $stable({bg_red, bg_green, bg_blue}));  // R4

    AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off != MODE_OFF && wr_off != BG_OFF) |=> !trc_valid);  // R8

    AST_WRITE_EMITS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_off == MODE_OFF || wr_off == BG_OFF)) |=> trc_valid
            && trc_subsys == SUBSYS_DISPLAY);  // R5

    AST_BG_EVENT_CODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == BG_OFF) |=> trc_event == EVT_BGCOL);  // R5

endmodule

// File: tb/tb_disp_priv_regs.sv
module tb_disp_priv_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_off;
    logic [63:0] wr_data;
    logic [7:0]  bg_red, bg_green, bg_blue;
    logic        trc_valid;
    logic [7:0]  trc_subsys, trc_event;
    logic [63:0] trc_arg0, trc_arg1, trc_arg2, trc_arg3;
    logic [31:0] trc_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [23:0] m_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_priv_regs dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .bg_red(bg_red), .bg_green(bg_green), .bg_blue(bg_blue),
        .trc_valid(trc_valid), .trc_subsys(trc_subsys), .trc_event(trc_event),
        .trc_arg0(trc_arg0), .trc_arg1(trc_arg1), .trc_arg2(trc_arg2),
        .trc_arg3(trc_arg3), .trc_flags(trc_flags)
    );

    function automatic logic [7:0] exp_code(input logic [15:0] off);
        if (off == 16'h00E0) return 8'h10;
        if (off == 16'h0000) return 8'h11;
        return 8'h00;
    endfunction

    function automatic logic [23:0] next_colour(input logic [23:0] cur, input logic en,
                                                input logic [15:0] off, input logic [63:0] d);
        if (en && off == 16'h00E0) return d[23:0];
        return cur;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [15:0] off, input logic [63:0] d,
                        input string req);
        logic        rec;
        logic [23:0] prev;
        rec  = en && (exp_code(off) != 8'h00);
        prev = m_col;
        wr_en = en; wr_off = off; wr_data = d;
        @(negedge clk);
        m_col = next_colour(m_col, en, off, d);
        check({req, " colour"}, {bg_red, bg_green, bg_blue}, m_col);
        check({req, " R6 valid"}, trc_valid, rec);
        if (rec) begin
            check({req, " R5 codes"}, {trc_subsys, trc_event}, {8'h02, exp_code(off)});
            check({req, " R7 args"}, {trc_arg0, trc_arg1}, {48'h0, off, d});
            check({req, " R7 reserved"}, {trc_arg2, trc_arg3, trc_flags}, 0);
        end else begin
            check({req, " R7 idle zero"}, {trc_subsys, trc_event, trc_arg0, trc_arg1}, 0);
        end
        if (!(en && off == 16'h00E0))
            check({req, " R3 hold"}, {bg_red, bg_green, bg_blue}, prev);
        wr_en = 1'b0; wr_off = '0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0; wr_off = '0; wr_data = '0;
        @(negedge clk);
        @(negedge clk);
        m_col = 24'h404040;
        check("R1 reset colour", {bg_red, bg_green, bg_blue}, 24'h404040);
        check("R1 reset valid", trc_valid, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        m_col = 24'h404040;
        do_reset();
        step(1'b0, 16'h0000, 64'h0, "R3 idle");
        step(1'b1, 16'h00E0, 64'h0000_0000_00AA_BBCC, "R2 first colour");
        repeat (20) step(1'b0, 16'h00E0, 64'hFFFF, "R3 long hold");
        step(1'b1, 16'h0000, 64'h1, "R4 mode write");
        step(1'b1, 16'h00E0, 64'hDEAD_BEEF_CA11_2233, "R9 upper bits ignored");
        step(1'b1, 16'h00E0, 64'h0000_0000_0044_5566, "R10 overwrite");
        step(1'b1, 16'h00E1, 64'h0000_0000_0099_9999, "R8 near offset");
        step(1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8 top offset");
        step(1'b1, 16'h00E0, 64'h0000_0000_0001_0203, "R6 back to back a");
        step(1'b1, 16'h0000, 64'h0000_0000_00FF_FFFF, "R6 back to back b");
        step(1'b1, 16'h00E0, 64'h0000_0000_00FE_DCBA, "R5 back to back c");
        for (int i = 0; i < 400; i++) begin
            logic [15:0] off;
            logic [63:0] d;
            int sel;
            sel = $urandom_range(0, 3);
            off = (sel == 0) ? 16'h00E0 : (sel == 1) ? 16'h0000 : 16'($urandom);
            d = {$urandom, $urandom};
            step(1'($urandom_range(0, 1)), off, d, "R2 random");
        end
        step(1'b1, 16'h00E0, 64'h0000_0000_0012_3456, "R10 before reset");
        do_reset();
        step(1'b0, 16'h0, 64'h0, "R1 after reset idle");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule